// File: doc/BRIEF.md
# Display Line Decimation Controller

This block decides, for every display line, whether the line is shown or thrown away. Downstream gate and timing logic uses its one-bit qualifier to suppress dropped lines. The decision follows one of two fixed patterns. In the long pattern, two lines out of every fourteen are removed. In the short pattern, one line out of every four is removed. A mode bit picks the pattern and a separate enable bit turns thinning on or off.

The block counts lines from a line strobe. A vertical start restarts that count, so every frame has the same pattern. The enable and mode inputs are captured only at a vertical start. Changing them in the middle of a frame has no effect until the next frame. After reset no thinning occurs, and every line is kept until a vertical start captures a configuration that enables thinning.

Top module: `line_thin`

## Requirements
- R1: After reset, `keepLine` is 1, and the captured enable and mode are both 0, until the first `frameStart`.
- R2: A `frameStart` sets the line index to 0. The line at index 0 is always kept. `keepLine` shows the decision for a strobed line from the first clock edge after the strobe.
- R3: If `thinEn` is 0 when `frameStart` is sampled, every line of that frame has `keepLine` = 1.
- R4: If `thinEn` = 1 and `thinMode` = 0 when `frameStart` is sampled, the line index runs 0 to 13 and then wraps to 0. Lines at index 6 and 13 are dropped (`keepLine` = 0) and all other lines are kept.
- R5: If `thinEn` = 1 and `thinMode` = 1 when `frameStart` is sampled, the line index runs 0 to 3 and then wraps to 0. The line at index 3 is dropped and all other lines are kept.
- R6: Changes on `thinEn` or `thinMode` when no `frameStart` is present have no effect on `keepLine` until the next `frameStart`.
- R7: If `frameStart` and `lineStb` are high in the same cycle, `frameStart` takes priority and the line index becomes 0.
- R8: Each `lineStb` without `frameStart` advances the line index by one. In a cycle with neither strobe, `keepLine` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineStb | input | 1 | One-cycle pulse at the start of each display line |
| frameStart | input | 1 | One-cycle vertical start pulse; restarts the pattern and captures configuration |
| thinEn | input | 1 | Thinning enable (1 = on), captured at `frameStart` |
| thinMode | input | 1 | Pattern select (0 = 2 of 14, 1 = 1 of 4), captured at `frameStart` |
| keepLine | output | 1 | 1 = current line kept, 0 = line dropped |

## Verification
Every result appears exactly one clock edge after the strobe that causes it. The bench drives each strobe on a falling edge for one cycle and reads `keepLine` at the next falling edge, when the rising edge has updated the register and no input is changing. In the gaps between strobes, the bench reads `keepLine` on each falling edge to confirm that it holds. Expected values come from the line index since the last vertical start, taken modulo 14 or 4, together with the enable and mode values the bench applied at that vertical start.

// File: rtl/line_thin_pkg.sv
package line_thin_pkg;

  // Configuration captured at each vertical start
  typedef struct packed {
    logic en;
    logic shortMode;
  } thinCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic advance;
  } phaseCmd_t;

endpackage

// File: rtl/line_thin_control.sv
module line_thin_control
  import line_thin_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      lineStb,
  input  logic      frameStart,
  input  logic      thinEn,
  input  logic      thinMode,
  output phaseCmd_t cmd,
  output thinCfg_t  cfgNext,
  output thinCfg_t  cfgCur
);

  // Configuration is only taken at a frame boundary
  always_comb begin
    cfgNext = cfgCur;
    if (frameStart) begin
      cfgNext.en        = thinEn;
      cfgNext.shortMode = thinMode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgCur <= '0;
    else       cfgCur <= cfgNext;
  end

  // Frame start has priority over a coincident line strobe
  always_comb begin
    cmd.restart = frameStart;
    cmd.advance = lineStb & ~frameStart;
  end

endmodule

// File: rtl/line_thin_datapath.sv
module line_thin_datapath
  import line_thin_pkg::*;
#(
  parameter int LONG_LEN    = 14,
  parameter int LONG_DROP_A = 6,
  parameter int LONG_DROP_B = 13,
  parameter int SHORT_LEN   = 4,
  parameter int SHORT_DROP  = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  phaseCmd_t cmd,
  input  thinCfg_t  cfgNext,
  output logic      keepLine
);

  localparam int MAX_LEN = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
  localparam int PHASE_W = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;
  localparam logic [PHASE_W-1:0] LONG_LAST  = PHASE_W'(LONG_LEN - 1);
  localparam logic [PHASE_W-1:0] SHORT_LAST = PHASE_W'(SHORT_LEN - 1);
  localparam logic [PHASE_W-1:0] L_DROP_A   = PHASE_W'(LONG_DROP_A);
  localparam logic [PHASE_W-1:0] L_DROP_B   = PHASE_W'(LONG_DROP_B);
  localparam logic [PHASE_W-1:0] S_DROP     = PHASE_W'(SHORT_DROP);

  logic [PHASE_W-1:0] phase, phaseNext, lastPhase;
  logic               dropNext;

  assign lastPhase = cfgNext.shortMode ? SHORT_LAST : LONG_LAST;

  always_comb begin
    phaseNext = phase;
    if (cmd.restart)
      phaseNext = '0;
    else if (cmd.advance)
      phaseNext = (phase == lastPhase) ? '0 : phase + 1'b1;
  end

  always_comb begin
    if (!cfgNext.en)
      dropNext = 1'b0;
    else if (cfgNext.shortMode)
      dropNext = (phaseNext == S_DROP);
    else
      dropNext = (phaseNext == L_DROP_A) || (phaseNext == L_DROP_B);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= '0;
      keepLine <= 1'b1;
    end else begin
      phase    <= phaseNext;
      keepLine <= ~dropNext;
    end
  end

endmodule

// File: rtl/line_thin.sv
module line_thin
  import line_thin_pkg::*;
#(
  parameter int LONG_LEN    = 14,
  parameter int LONG_DROP_A = 6,
  parameter int LONG_DROP_B = 13,
  parameter int SHORT_LEN   = 4,
  parameter int SHORT_DROP  = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineStb,
  input  logic frameStart,
  input  logic thinEn,
  input  logic thinMode,
  output logic keepLine
);

  phaseCmd_t cmd;
  thinCfg_t  cfgNext;
  thinCfg_t  cfgCur;

  line_thin_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lineStb   (lineStb),
    .frameStart(frameStart),
    .thinEn    (thinEn),
    .thinMode  (thinMode),
    .cmd       (cmd),
    .cfgNext   (cfgNext),
    .cfgCur    (cfgCur)
  );

  line_thin_datapath #(
    .LONG_LEN   (LONG_LEN),
    .LONG_DROP_A(LONG_DROP_A),
    .LONG_DROP_B(LONG_DROP_B),
    .SHORT_LEN  (SHORT_LEN),
    .SHORT_DROP (SHORT_DROP)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .cfgNext (cfgNext),
    .keepLine(keepLine)
  );

endmodule

// File: rtl/line_thin_checker.sv
module line_thin_checker (
  input logic       clk,
  input logic       rstN,
  input logic       lineStb,
  input logic       frameStart,
  input logic       keepLine,
  input logic [1:0] cfgCur
);

  // R2, R7: index 0 after a frame start is never dropped
  a_r2_first_line_kept: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> keepLine);

  // R6: captured configuration moves only at a frame start
  a_r6_cfg_frame_only: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(cfgCur));

  // R8: output holds with no strobe
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!lineStb && !frameStart) |=> $stable(keepLine));

  // R4, R5: drop positions are never adjacent, including across the wrap
  a_r4_no_double_drop: assert property (@(posedge clk) disable iff (!rstN)
    (!keepLine && lineStb) |=> keepLine);

  // R3: disabled configuration never drops
  a_r3_off_keeps: assert property (@(posedge clk) disable iff (!rstN)
    !cfgCur[1] |-> keepLine);

endmodule

bind line_thin line_thin_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .lineStb   (lineStb),
  .frameStart(frameStart),
  .keepLine  (keepLine),
  .cfgCur    (cfgCur)
);

// File: tb/line_thin_bench.sv
module line_thin_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineStb = 1'b0;
  logic frameStart = 1'b0;
  logic thinEn = 1'b0;
  logic thinMode = 1'b0;
  logic keepLine;

  int nChecks = 0;
  int nFails = 0;
  int lineIdx = 0;
  logic capEn = 1'b0;
  logic capMode = 1'b0;

  always #2 clk = ~clk;

  line_thin u_line_thin (
    .clk(clk), .rstN(rstN), .lineStb(lineStb), .frameStart(frameStart),
    .thinEn(thinEn), .thinMode(thinMode), .keepLine(keepLine)
  );

  function automatic logic expKeep(int idx, logic en, logic md);
    if (!en) return 1'b1;
    if (md) return (idx % 4) != 3;
    return !((idx % 14) == 6 || (idx % 14) == 13);
  endfunction

  task automatic check(string req, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: keepLine=%0b expected=%0b (line %0d)", req, act, exp, lineIdx);
    end
  endtask

  // Drive a strobe on a falling edge, then sample at the next falling edge
  task automatic strobe(logic fs, logic ls, string req);
    lineStb = ls;
    frameStart = fs;
    if (fs) begin
      lineIdx = 0;
      capEn = thinEn;
      capMode = thinMode;
    end else if (ls) begin
      lineIdx++;
    end
    @(negedge clk);
    lineStb = 1'b0;
    frameStart = 1'b0;
    check(req, keepLine, expKeep(lineIdx, capEn, capMode));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R8", keepLine, expKeep(lineIdx, capEn, capMode));
    end
  endtask

  task automatic runFrame(logic en, logic md, int lines, int gap, string req);
    thinEn = en;
    thinMode = md;
    strobe(1'b1, 1'b0, "R2");
    for (int l = 1; l <= lines; l++) begin
      idle(gap);
      strobe(1'b0, 1'b1, req);
    end
  endtask

  initial begin
    #(200000 * 4);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", keepLine, 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    // R1: enable on the inputs, but no frame start yet -> nothing dropped
    thinEn = 1'b1;
    thinMode = 1'b0;
    for (int l = 0; l < 20; l++) strobe(1'b0, 1'b1, "R1");

    // R3: off in both modes
    runFrame(1'b0, 1'b0, 30, 0, "R3");
    runFrame(1'b0, 1'b1, 30, 1, "R3");
    // R4: long pattern with several gap lengths
    for (int g = 0; g < 3; g++) runFrame(1'b1, 1'b0, 45, g, "R4");
    // R5: short pattern
    for (int g = 0; g < 3; g++) runFrame(1'b1, 1'b1, 21, g, "R5");

    // R6: toggle the inputs mid-frame; the captured config must persist
    thinEn = 1'b1;
    thinMode = 1'b1;
    strobe(1'b1, 1'b0, "R2");
    for (int l = 1; l <= 30; l++) begin
      thinMode = l[0];
      thinEn = l[1];
      strobe(1'b0, 1'b1, "R6");
    end
    thinEn = 1'b1;
    thinMode = 1'b0;
    strobe(1'b1, 1'b0, "R2");
    for (int l = 1; l <= 30; l++) begin
      thinMode = ~l[0];
      thinEn = l[2];
      strobe(1'b0, 1'b1, "R6");
      idle(1);
    end

    // R7: coincident strobes restart at index 0, even mid-cycle of the pattern
    thinEn = 1'b1;
    thinMode = 1'b1;
    strobe(1'b1, 1'b0, "R2");
    for (int l = 1; l <= 3; l++) strobe(1'b0, 1'b1, "R5");
    strobe(1'b1, 1'b1, "R7");
    for (int l = 1; l <= 8; l++) strobe(1'b0, 1'b1, "R7");
    thinMode = 1'b0;
    strobe(1'b1, 1'b1, "R7");
    for (int l = 1; l <= 14; l++) strobe(1'b0, 1'b1, "R7");

    // R8: long idle on a dropped line keeps it dropped
    thinMode = 1'b1;
    strobe(1'b1, 1'b0, "R2");
    for (int l = 1; l <= 3; l++) strobe(1'b0, 1'b1, "R5");
    idle(10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule